// File: doc/BRIEF.md
# Sequence-Committed Masked Settings Bank

This block holds a device-side bank of mixer settings that a host updates through a small register window. The host stages new contents for any number of settings, and each staged word carries a 16-bit value half together with a 16-bit change mask. Staging alone changes nothing visible. The block acts only when the host changes its sequence register. It then walks the bank one setting per cycle and merges each staged value into the active setting, so that only bits whose mask bit is set are updated. The staged masks are cleared as they are consumed. After the last setting has been merged, the block copies the sequence number into its acknowledgment register.

Every setting owns two words in the window, but only one of them drives the 16-bit active value, and which one depends on the setting index. The whole mechanism stays idle until the host has written the enabling code to the clock-source register. All active settings are presented together on a wide parallel output for downstream logic.

Top module: `seqmask_settings_bank`

## Requirements
- R1: After synchronous reset every active setting is 0, and reads of the clock-source register (byte offset 0x04), the host sequence register (0x08) and the acknowledgment register (0x0C) return 0.
- R2: A staging write leaves `settings_o` unchanged until a commit triggered by the sequence register merges it.
- R3: During a commit, active bit i of a setting becomes the staged value bit i where the staged mask bit i is 1, and keeps its previous value where the mask bit is 0.
- R4: Setting k owns byte offsets 0x10+8k (word A) and 0x14+8k (word B). Settings 0 to 31 are staged through word B only and settings 32 to 37 through word A only. A write to the other word is ignored, and a read of it returns 0.
- R5: A staging word carries the mask in bits 31:16 and the value in bits 15:0. A read of a setting's active word returns {staged mask, active value}, and `settings_o[16k+15:16k]` is setting k.
- R6: Commits are possible only once the value 0x0000000C has been written to the clock-source register. The enable then stays set whatever is written there later. Sequence writes made before that never start a commit, not even after enabling.
- R7: A commit is requested only by a write to 0x08 whose data differs from the register's current contents. Rewriting the same value does nothing.
- R8: For a request written at clock edge E0, the commit starts at E1, merges setting k at edge E2+k, and loads the acknowledgment register with the sequence value captured at E1 on edge E39, together with the last merge.
- R9: Each setting's staged mask is cleared when that setting is merged, so a later commit without new staging leaves every active setting unchanged.
- R10: A staging write that lands on a setting in the same edge as its merge is kept staged for the next commit, and that merge uses the older staged word. A changing sequence write made during a commit is remembered and starts a further commit once the current one ends.
- R11: Reads are registered: `rd_data` shows the addressed register one cycle after `rd_en`, holds otherwise, and is 0 for an unmapped or misaligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register window |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Byte address of the read |
| rd_data | output | 32 | Registered read data |
| settings_o | output | 608 | All active settings, 16 bits each, setting 0 in the low bits |

## Verification
Two functions can fall on the same edge: the host staging a setting and the commit walker merging that same setting. The bench counts edges from the sequence write and places a staging write on setting 5 so that it lands exactly on that setting's merge edge. It then expects the old staged word to be applied and the new mask still to read back as staged. A second changing sequence write during the same walk must produce a follow-up commit. That commit merges the late word, which the bench checks between the two commits and after the second.

// File: rtl/msb_pkg.sv
package msb_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int N_SET_DEF   = 38;
    localparam int SPLIT_DEF   = 32;
    localparam int ADDR_W_DEF  = 9;

    // Register window layout (byte offsets)
    localparam int OFF_CLKSRC  = 4;
    localparam int OFF_HOSTSEQ = 8;
    localparam int OFF_ACK     = 12;
    localparam int OFF_SLOTS   = 16;
    localparam int SLOT_BYTES  = 8;

    localparam logic [DATA_W-1:0] CLK_ENABLE_CODE = 32'h0000_000C;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WALK = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] mask;
        logic [HALF_W-1:0] value;
    } half_t;

    function automatic half_t unpack_half(input logic [DATA_W-1:0] w);
        half_t h;
        h.mask  = w[DATA_W-1:HALF_W];
        h.value = w[HALF_W-1:0];
        return h;
    endfunction

    function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] cur,
                                                     input half_t st);
        return (cur & ~st.mask) | (st.value & st.mask);
    endfunction

endpackage

// File: rtl/msb_stage.sv
module msb_stage
    import msb_pkg::*;
#(
    parameter int N_SET = N_SET_DEF,
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    output half_t [N_SET-1:0]       stage_o
);

    for (genvar s = 0; s < N_SET; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_o[s] <= '0;
            end else if (we && widx == IDX_W'(s)) begin
                // host write wins over the walker's clear in the same edge
                stage_o[s] <= unpack_half(wdata);
            end else if (clr_en && clr_idx == IDX_W'(s)) begin
                stage_o[s].mask <= '0;
            end
        end
    end

endmodule

// File: rtl/msb_active.sv
module msb_active
    import msb_pkg::*;
#(
    parameter int N_SET = N_SET_DEF,
    parameter int IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          merge_en,
    input  logic [IDX_W-1:0]              merge_idx,
    input  half_t [N_SET-1:0]             stage_i,
    output logic [N_SET-1:0][HALF_W-1:0]  act_o
);

    for (genvar s = 0; s < N_SET; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                act_o[s] <= '0;
            end else if (merge_en && merge_idx == IDX_W'(s)) begin
                act_o[s] <= merge_half(act_o[s], stage_i[s]);
            end
        end
    end

endmodule

// File: rtl/msb_sequencer.sv
module msb_sequencer
    import msb_pkg::*;
#(
    parameter int N_SET = N_SET_DEF,
    parameter int IDX_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_we,
    input  logic               seq_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  clk_src_o,
    output logic [DATA_W-1:0]  host_seq_o,
    output logic [DATA_W-1:0]  ack_o,
    output logic               en_o,
    output logic               busy_o,
    output logic               start_o,
    output logic [IDX_W-1:0]   walk_idx_o
);

    seq_state_e        state;
    logic              pending;
    logic [DATA_W-1:0] target;
    logic              last;

    assign busy_o  = (state == SEQ_WALK);
    assign start_o = (state == SEQ_IDLE) && pending;
    assign last    = (walk_idx_o == IDX_W'(N_SET - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            pending    <= 1'b0;
            target     <= '0;
            walk_idx_o <= '0;
            clk_src_o  <= '0;
            host_seq_o <= '0;
            ack_o      <= '0;
            en_o       <= 1'b0;
        end else begin
            if (clk_we) begin
                clk_src_o <= wdata;
                if (wdata == CLK_ENABLE_CODE) begin
                    en_o <= 1'b1;
                end
            end
            if (start_o) begin
                state      <= SEQ_WALK;
                walk_idx_o <= '0;
                target     <= host_seq_o;
                pending    <= 1'b0;
            end
            if (state == SEQ_WALK) begin
                if (last) begin
                    state <= SEQ_IDLE;
                    ack_o <= target;
                end else begin
                    walk_idx_o <= walk_idx_o + IDX_W'(1);
                end
            end
            // a changing sequence write is remembered, even mid-walk
            if (seq_we) begin
                host_seq_o <= wdata;
                if (en_o && wdata != host_seq_o) begin
                    pending <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seqmask_settings_bank.sv
module seqmask_settings_bank
    import msb_pkg::*;
#(
    parameter int N_SET  = N_SET_DEF,
    parameter int SPLIT  = SPLIT_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [N_SET*HALF_W-1:0]    settings_o
);

    localparam int IDX_W    = (N_SET > 1) ? $clog2(N_SET) : 1;
    localparam int SLOT_END = OFF_SLOTS + SLOT_BYTES * N_SET;
    localparam int SLOT_AW  = ADDR_W - 3;

    // ---------------- address decode ----------------
    logic               wr_in_slots, rd_in_slots;
    logic [SLOT_AW-1:0] wr_slot_raw, rd_slot_raw;
    logic [IDX_W-1:0]   wr_slot, rd_slot;
    logic               wr_owned, rd_owned;
    logic               stage_we, clk_we, seq_we;

    assign wr_in_slots = (wr_addr[1:0] == 2'b00) && (32'(wr_addr) >= OFF_SLOTS)
                         && (32'(wr_addr) < SLOT_END);
    assign rd_in_slots = (rd_addr[1:0] == 2'b00) && (32'(rd_addr) >= OFF_SLOTS)
                         && (32'(rd_addr) < SLOT_END);
    assign wr_slot_raw = wr_addr[ADDR_W-1:3] - SLOT_AW'(OFF_SLOTS / SLOT_BYTES);
    assign rd_slot_raw = rd_addr[ADDR_W-1:3] - SLOT_AW'(OFF_SLOTS / SLOT_BYTES);
    assign wr_slot     = IDX_W'(wr_slot_raw);
    assign rd_slot     = IDX_W'(rd_slot_raw);
    // low settings live in word B (bit 2 set), high settings in word A
    assign wr_owned    = (wr_addr[2] == (32'(wr_slot) < SPLIT));
    assign rd_owned    = (rd_addr[2] == (32'(rd_slot) < SPLIT));

    assign stage_we = wr_en && wr_in_slots && wr_owned;
    assign clk_we   = wr_en && (wr_addr == ADDR_W'(OFF_CLKSRC));
    assign seq_we   = wr_en && (wr_addr == ADDR_W'(OFF_HOSTSEQ));

    // ---------------- submodules ----------------
    logic [DATA_W-1:0]               clk_src, host_seq, seq_ack;
    logic                            proc_en, busy, commit_start;
    logic [IDX_W-1:0]                walk_idx;
    half_t [N_SET-1:0]               stage;
    logic [N_SET-1:0][HALF_W-1:0]    active;

    msb_sequencer #(.N_SET(N_SET), .IDX_W(IDX_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .clk_we     (clk_we),
        .seq_we     (seq_we),
        .wdata      (wr_data),
        .clk_src_o  (clk_src),
        .host_seq_o (host_seq),
        .ack_o      (seq_ack),
        .en_o       (proc_en),
        .busy_o     (busy),
        .start_o    (commit_start),
        .walk_idx_o (walk_idx)
    );

    msb_stage #(.N_SET(N_SET), .IDX_W(IDX_W)) i_stage (
        .clk     (clk),
        .rst     (rst),
        .we      (stage_we),
        .widx    (wr_slot),
        .wdata   (wr_data),
        .clr_en  (busy),
        .clr_idx (walk_idx),
        .stage_o (stage)
    );

    msb_active #(.N_SET(N_SET), .IDX_W(IDX_W)) i_active (
        .clk       (clk),
        .rst       (rst),
        .merge_en  (busy),
        .merge_idx (walk_idx),
        .stage_i   (stage),
        .act_o     (active)
    );

    assign settings_o = active;

    // ---------------- registered read ----------------
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (rd_addr == ADDR_W'(OFF_CLKSRC)) begin
            rd_mux = clk_src;
        end else if (rd_addr == ADDR_W'(OFF_HOSTSEQ)) begin
            rd_mux = host_seq;
        end else if (rd_addr == ADDR_W'(OFF_ACK)) begin
            rd_mux = seq_ack;
        end else if (rd_in_slots && rd_owned) begin
            rd_mux = {stage[rd_slot].mask, active[rd_slot]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/msb_checker.sv
module msb_checker
    import msb_pkg::*;
#(
    parameter int N_SET = N_SET_DEF,
    parameter int IDX_W = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     busy,
    input logic                     start,
    input logic                     en,
    input logic [IDX_W-1:0]         walk_idx,
    input logic [DATA_W-1:0]        ack,
    input logic [N_SET*HALF_W-1:0]  settings
);

    // R2: active settings move only while a commit walk is in progress
    assert_settings_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(settings));

    // R6: no commit begins without the enable
    assert_no_commit_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> en);

    // R8: acknowledgment changes only on the edge that merges the last setting
    assert_ack_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ack) |-> ($past(busy) && $past(walk_idx) == IDX_W'(N_SET - 1)));

    // R8: a walk always finishes on the last setting
    assert_walk_ends_last_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(walk_idx) == IDX_W'(N_SET - 1)));

    // R8: walker index stays inside the bank
    assert_walk_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (32'(walk_idx) < N_SET));

endmodule

bind seqmask_settings_bank msb_checker #(.N_SET(N_SET), .IDX_W(IDX_W)) i_msb_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .start    (commit_start),
    .en       (proc_en),
    .walk_idx (walk_idx),
    .ack      (seq_ack),
    .settings (settings_o)
);

// File: tb/test_seqmask_settings_bank.sv
module test_seqmask_settings_bank;

    localparam int N     = 38;
    localparam int SPLIT = 32;
    localparam int AW    = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [31:0]       rd_data;
    logic [N*16-1:0]   settings_o;

    always #4 clk = ~clk;   // 125 MHz

    seqmask_settings_bank i_seqmask_settings_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .settings_o(settings_o)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [15:0] exp_act [N];
    logic [15:0] exp_val [N];
    logic [15:0] exp_msk [N];
    logic [31:0] cur_seq;

    function automatic logic [AW-1:0] word_addr(int s, bit b);
        return AW'(16 + 8 * s + (b ? 4 : 0));
    endfunction

    function automatic logic [AW-1:0] own_addr(int s);
        return word_addr(s, s < SPLIT);
    endfunction

    function automatic logic [15:0] merged(logic [15:0] c, logic [15:0] v, logic [15:0] m);
        return (c & ~m) | (v & m);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic stage(int s, logic [15:0] v, logic [15:0] m);
        wr(own_addr(s), {m, v});
        exp_val[s] = v;
        exp_msk[s] = m;
    endtask

    task automatic model_commit();
        for (int s = 0; s < N; s++) begin
            exp_act[s] = merged(exp_act[s], exp_val[s], exp_msk[s]);
            exp_msk[s] = '0;
        end
    endtask

    task automatic check_all(string req);
        for (int s = 0; s < N; s++)
            chk(req, $sformatf("setting %0d", s), 32'(settings_o[16*s +: 16]), 32'(exp_act[s]));
    endtask

    task automatic seq_write(logic [31:0] v);
        wr(AW'(8), v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd2024));
        for (int s = 0; s < N; s++) begin
            exp_act[s] = '0; exp_val[s] = '0; exp_msk[s] = '0;
        end
        cur_seq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_all("R1");
        rd(AW'(4), r);  chk("R1", "clock source", r, 32'h0);
        rd(AW'(8), r);  chk("R1", "host seq", r, 32'h0);
        rd(AW'(12), r); chk("R1", "ack", r, 32'h0);

        // R6 sequence change before enable is ignored
        stage(3, 16'hABCD, 16'h0FF0);
        rd(own_addr(3), r); chk("R5", "staged readback", r, 32'h0FF0_0000);
        seq_write(32'd1);
        repeat (50) @(negedge clk);
        check_all("R6");
        rd(AW'(12), r); chk("R6", "ack while disabled", r, 32'h0);

        // enable; the earlier change must not be replayed
        wr(AW'(4), 32'h0000_000C);
        repeat (50) @(negedge clk);
        check_all("R6");
        rd(AW'(12), r); chk("R6", "ack after enable", r, 32'h0);

        // R7 same value does not commit
        seq_write(32'd1);
        repeat (50) @(negedge clk);
        check_all("R7");
        // R6 sticky enable, then a changing write commits (R3, R5)
        wr(AW'(4), 32'h0000_0001);
        rd(AW'(4), r); chk("R6", "clock source readback", r, 32'h1);
        cur_seq = 32'd2;
        seq_write(cur_seq);
        model_commit();
        repeat (45) @(negedge clk);
        check_all("R3");
        chk("R5", "masked merge slot 3", 32'(settings_o[48 +: 16]), 32'h0BC0);
        rd(AW'(12), r); chk("R8", "ack value", r, cur_seq);
        rd(own_addr(3), r); chk("R9", "mask cleared", r, 32'h0000_0BC0);

        // R4 boundary slots 31 and 32, other word ignored and reads 0
        wr(word_addr(31, 1'b0), 32'hFFFF_1111);
        wr(word_addr(32, 1'b1), 32'hFFFF_2222);
        stage(31, 16'h3131, 16'hFFFF);
        stage(32, 16'h3232, 16'hFFFF);
        rd(word_addr(31, 1'b0), r); chk("R4", "slot 31 word A reads 0", r, 32'h0);
        rd(word_addr(32, 1'b1), r); chk("R4", "slot 32 word B reads 0", r, 32'h0);
        rd(AW'(17), r); chk("R11", "misaligned read 0", r, 32'h0);
        cur_seq = cur_seq + 1;
        seq_write(cur_seq);
        model_commit();
        repeat (45) @(negedge clk);
        chk("R4", "slot 31", 32'(settings_o[16*31 +: 16]), 32'h3131);
        chk("R4", "slot 32", 32'(settings_o[16*32 +: 16]), 32'h3232);

        // random batches with junk writes to non-owned words
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 12; i++) begin
                int s;
                s = int'($urandom_range(N - 1));
                stage(s, 16'($urandom), 16'($urandom));
                s = int'($urandom_range(N - 1));
                wr(word_addr(s, !(s < SPLIT)), $urandom);
            end
            check_all("R2");
            cur_seq = cur_seq + 1;
            seq_write(cur_seq);
            model_commit();
            repeat (45) @(negedge clk);
            check_all("R3");
            rd(AW'(12), r); chk("R8", "ack after batch", r, cur_seq);
            rd(AW'(8), r);  chk("R11", "host seq readback", r, cur_seq);
        end

        // R9 commit with nothing staged changes nothing
        cur_seq = cur_seq + 1;
        seq_write(cur_seq);
        repeat (45) @(negedge clk);
        check_all("R9");

        // R8 exact timing: slot k merged at E2+k, ack at E39
        stage(0, 16'h1234, 16'hFFFF);
        stage(1, 16'h5678, 16'hFFFF);
        cur_seq = cur_seq + 1;
        seq_write(cur_seq);          // returns after E0
        @(negedge clk);              // after E1
        chk("R8", "slot0 before merge", 32'(settings_o[15:0]), 32'(exp_act[0]));
        @(negedge clk);              // after E2
        chk("R8", "slot0 merged at E2", 32'(settings_o[15:0]), 32'h1234);
        chk("R8", "slot1 not yet", 32'(settings_o[31:16]), 32'(exp_act[1]));
        @(negedge clk);              // after E3
        chk("R8", "slot1 merged at E3", 32'(settings_o[31:16]), 32'h5678);
        repeat (34) @(negedge clk);  // after E37
        rd(AW'(12), r); chk("R8", "ack before last merge", r, cur_seq - 1);
        rd(AW'(12), r); chk("R8", "ack after last merge", r, cur_seq);
        model_commit();

        // R10 collision on slot 5 and a queued sequence write
        stage(5, 16'hAAAA, 16'hFFFF);
        cur_seq = cur_seq + 1;
        seq_write(cur_seq);          // after E0
        repeat (5) @(negedge clk);   // after E5
        wr(own_addr(5), {16'h00FF, 16'h5555});   // sampled at E7
        seq_write(cur_seq + 1);      // sampled at E9, returns after E9
        repeat (31) @(negedge clk);  // after E40
        chk("R10", "slot5 used older word", 32'(settings_o[16*5 +: 16]), 32'hAAAA);
        rd(own_addr(5), r); chk("R10", "late mask still staged", r, 32'h00FF_AAAA);
        repeat (60) @(negedge clk);
        chk("R10", "queued commit merged slot5", 32'(settings_o[16*5 +: 16]), 32'hAA55);
        rd(AW'(12), r); chk("R10", "queued commit ack", r, cur_seq + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule